// File: doc/BRIEF.md
# Segmented Physical Address Generator

This combinational unit turns a 16-bit offset and one of four 16-bit segment registers into a 20-bit physical address. The segment value is shifted left by four bits and the offset is added. The offset comes from one of three places. An instruction fetch uses the instruction pointer. A stack access uses the stack pointer. A data access computes an effective address from a displacement, an optional base register and an optional index register, as the addressing mode selects.

The segment is picked from the access kind and the registers in use. Code always uses the code segment. Stack always uses the stack segment. A data access defaults to the stack segment when it goes through the BP base pointer, and to the data segment otherwise. A data access may instead name any segment through the override inputs. The offset sum is kept to 16 bits and the physical sum to 20 bits, so both wrap.

The caller decodes instructions and drives the register values. The outputs feed a memory port directly.

Top module: `seg_addr_unit`

## Requirements
- R1: `phys_addr` equals (segment value × 16 + `eff_addr`) modulo 2^20, where the segment value is the register named by `seg_sel`. Segment codes are 0 = extra (`seg_es`), 1 = code (`seg_cs`), 2 = stack (`seg_ss`), 3 = data (`seg_ds`). For example, 0x0100 with 0x0123 gives 0x01123.
- R2: With `access_kind` 0 (code), `eff_addr` is `reg_ip` and `seg_sel` is 1. The addressing mode and the override inputs are ignored. For example, CS 0x0100 with IP 0x4321 gives 0x05321.
- R3: With `access_kind` 2 (stack), `eff_addr` is `reg_sp` and `seg_sel` is 2. The override inputs are ignored.
- R4: Data access, `addr_mode` 0 (direct): `eff_addr` is `disp`, and the default segment is data (3).
- R5: Data access, `addr_mode` 1 (register indirect through a base): `eff_addr` is BX when `base_pick` is 0 and BP when it is 1. Data access, `addr_mode` 2 (register indirect through an index): `eff_addr` is SI when `index_pick` is 0 and DI when it is 1. Indirect access through BP defaults to segment 2. The other registers default to segment 3.
- R6: Data access, `addr_mode` 3 (based): `eff_addr` is (base + `disp`) mod 2^16. The default segment is 2 for BP and 3 for BX.
- R7: Data access, `addr_mode` 4 (indexed): `eff_addr` is (index + `disp`) mod 2^16, with default segment 3.
- R8: Data access, `addr_mode` 5 (based-indexed): `eff_addr` is (base + index + `disp`) mod 2^16. The default segment is 2 when the base is BP and 3 when it is BX.
- R9: For a data access with `ovr_en` high, `seg_sel` equals `ovr_seg` whatever the default would have been.
- R10: The physical sum wraps past 0xFFFFF. With segment 0xFF20, offset 0x0DFF gives 0xFFFFF, offset 0x0E00 gives 0x00000, and offset 0xFFFF gives 0x0F1FF.
- R11: The unused mode codes 6 and 7 behave as direct (mode 0). `access_kind` 3 behaves as a data access (kind 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| seg_es | input | 16 | Extra segment register |
| seg_cs | input | 16 | Code segment register |
| seg_ss | input | 16 | Stack segment register |
| seg_ds | input | 16 | Data segment register |
| reg_bx | input | 16 | Base register BX |
| reg_bp | input | 16 | Base pointer BP |
| reg_si | input | 16 | Source index SI |
| reg_di | input | 16 | Destination index DI |
| reg_ip | input | 16 | Instruction pointer |
| reg_sp | input | 16 | Stack pointer |
| disp | input | 16 | Displacement or direct address |
| addr_mode | input | 3 | Data addressing mode (0..5, 6 and 7 as 0) |
| access_kind | input | 2 | 0 code, 1 data, 2 stack, 3 as data |
| base_pick | input | 1 | 0 selects BX, 1 selects BP |
| index_pick | input | 1 | 0 selects SI, 1 selects DI |
| ovr_en | input | 1 | Replace the default segment on data accesses |
| ovr_seg | input | 2 | Segment code used when overriding |
| eff_addr | output | 16 | Effective (offset) address |
| seg_sel | output | 2 | Segment code in use |
| phys_addr | output | 20 | 20-bit physical address |

## Verification
The stimulus covers each addressing mode with each base and index choice. These vectors tell a BX-based access (data segment) from a BP-based one (stack segment), and an index register from a base register. Register values are chosen so that every source gives a different result, so a swapped operand shows as a wrong offset. Offset sums that carry past 16 bits and segment values near 0xFFFF separate correct truncation and 20-bit wrap from a widened adder. Override vectors applied to code, stack and data accesses show whether the override acts only on data.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int OFF_W      = 16;
  localparam int SEG_SHIFT  = 4;
  localparam int PHYS_W     = OFF_W + SEG_SHIFT;
  localparam int SEG_COUNT  = 4;
  localparam int SEG_IDX_W  = $clog2(SEG_COUNT);
  localparam int MODE_W     = 3;
  localparam int KIND_W     = 2;

  typedef enum logic [SEG_IDX_W-1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;

  localparam logic [MODE_W-1:0] AM_DIRECT        = 3'd0;
  localparam logic [MODE_W-1:0] AM_IND_BASE      = 3'd1;
  localparam logic [MODE_W-1:0] AM_IND_INDEX     = 3'd2;
  localparam logic [MODE_W-1:0] AM_BASED         = 3'd3;
  localparam logic [MODE_W-1:0] AM_INDEXED       = 3'd4;
  localparam logic [MODE_W-1:0] AM_BASED_INDEXED = 3'd5;

  localparam logic [KIND_W-1:0] KIND_CODE  = 2'd0;
  localparam logic [KIND_W-1:0] KIND_DATA  = 2'd1;
  localparam logic [KIND_W-1:0] KIND_STACK = 2'd2;

  // Three-operand offset sum, truncated to the offset width.
  function automatic logic [OFF_W-1:0] ea_sum(
    input logic [OFF_W-1:0] base_v,
    input logic [OFF_W-1:0] index_v,
    input logic [OFF_W-1:0] disp_v,
    input logic             use_base,
    input logic             use_index,
    input logic             use_disp
  );
    logic [OFF_W-1:0] b, x, d;
    b = use_base  ? base_v  : '0;
    x = use_index ? index_v : '0;
    d = use_disp  ? disp_v  : '0;
    return b + x + d;
  endfunction

  // Segment relocation: shift left and add, keeping PHYS_W bits.
  function automatic logic [PHYS_W-1:0] relocate(
    input logic [OFF_W-1:0] seg_v,
    input logic [OFF_W-1:0] off_v
  );
    logic [PHYS_W-1:0] s, o;
    s = {seg_v, {SEG_SHIFT{1'b0}}};
    o = {{SEG_SHIFT{1'b0}}, off_v};
    return s + o;
  endfunction
endpackage

// File: rtl/seg_ea_calc.sv
module seg_ea_calc
  import seg_addr_pkg::*;
(
  input  logic [OFF_W-1:0]  reg_bx,
  input  logic [OFF_W-1:0]  reg_bp,
  input  logic [OFF_W-1:0]  reg_si,
  input  logic [OFF_W-1:0]  reg_di,
  input  logic [OFF_W-1:0]  disp,
  input  logic [MODE_W-1:0] addr_mode,
  input  logic              base_pick,
  input  logic              index_pick,
  output logic [OFF_W-1:0]  ea,
  output logic              bp_involved
);
  logic [OFF_W-1:0] base_v, index_v;
  logic use_base, use_index, use_disp;

  assign base_v  = base_pick  ? reg_bp : reg_bx;
  assign index_v = index_pick ? reg_di : reg_si;

  always_comb begin
    use_base  = 1'b0;
    use_index = 1'b0;
    use_disp  = 1'b0;
    case (addr_mode)
      AM_IND_BASE:      use_base = 1'b1;
      AM_IND_INDEX:     use_index = 1'b1;
      AM_BASED:         begin use_base = 1'b1; use_disp = 1'b1; end
      AM_INDEXED:       begin use_index = 1'b1; use_disp = 1'b1; end
      AM_BASED_INDEXED: begin use_base = 1'b1; use_index = 1'b1; use_disp = 1'b1; end
      default:          use_disp = 1'b1; // direct and reserved codes (R4, R11)
    endcase
  end

  assign ea          = ea_sum(base_v, index_v, disp, use_base, use_index, use_disp);
  assign bp_involved = use_base & base_pick;

  // R5: an indirect access through the index path never involves BP.
  always_comb begin
    if (addr_mode == AM_IND_INDEX)
      p_index_no_bp_r5: assert (!bp_involved && ea == index_v)
        else $error("index indirect mismatch");
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [KIND_W-1:0]    access_kind,
  input  logic                 bp_involved,
  input  logic                 ovr_en,
  input  logic [SEG_IDX_W-1:0] ovr_seg,
  output seg_id_e              seg_id,
  output logic                 is_data
);
  assign is_data = (access_kind != KIND_CODE) && (access_kind != KIND_STACK);

  always_comb begin
    if (access_kind == KIND_CODE)       seg_id = SEG_CODE;
    else if (access_kind == KIND_STACK) seg_id = SEG_STACK;
    else if (ovr_en)                    seg_id = seg_id_e'(ovr_seg);
    else if (bp_involved)               seg_id = SEG_STACK;
    else                                seg_id = SEG_DATA;
  end
endmodule

// File: rtl/seg_relocate.sv
module seg_relocate
  import seg_addr_pkg::*;
(
  input  logic [OFF_W-1:0]  seg_file [SEG_COUNT],
  input  seg_id_e           seg_id,
  input  logic [OFF_W-1:0]  offset,
  output logic [OFF_W-1:0]  seg_value,
  output logic [PHYS_W-1:0] phys
);
  logic [SEG_COUNT-1:0] hit;
  logic [OFF_W-1:0]     masked [SEG_COUNT];

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    assign hit[g]    = (seg_id == seg_id_e'(SEG_IDX_W'(g)));
    assign masked[g] = seg_file[g] & {OFF_W{hit[g]}};
  end

  always_comb begin
    seg_value = '0;
    for (int i = 0; i < SEG_COUNT; i++) seg_value = seg_value | masked[i];
  end

  assign phys = relocate(seg_value, offset);

  // R1: exactly one segment register feeds the adder.
  always_comb begin
    p_one_segment_r1: assert ($countones(hit) == 1)
      else $error("segment select not one-hot");
  end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
(
  input  logic [15:0] seg_es,
  input  logic [15:0] seg_cs,
  input  logic [15:0] seg_ss,
  input  logic [15:0] seg_ds,
  input  logic [15:0] reg_bx,
  input  logic [15:0] reg_bp,
  input  logic [15:0] reg_si,
  input  logic [15:0] reg_di,
  input  logic [15:0] reg_ip,
  input  logic [15:0] reg_sp,
  input  logic [15:0] disp,
  input  logic [2:0]  addr_mode,
  input  logic [1:0]  access_kind,
  input  logic        base_pick,
  input  logic        index_pick,
  input  logic        ovr_en,
  input  logic [1:0]  ovr_seg,
  output logic [15:0] eff_addr,
  output logic [1:0]  seg_sel,
  output logic [19:0] phys_addr
);
  logic [OFF_W-1:0]  data_ea;
  logic              bp_involved;
  logic              is_data;
  seg_id_e           seg_id;
  logic [OFF_W-1:0]  seg_value;
  logic [PHYS_W-1:0] phys;
  logic [OFF_W-1:0]  seg_file [SEG_COUNT];

  assign seg_file[SEG_EXTRA] = seg_es;
  assign seg_file[SEG_CODE]  = seg_cs;
  assign seg_file[SEG_STACK] = seg_ss;
  assign seg_file[SEG_DATA]  = seg_ds;

  seg_ea_calc u_ea (
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .disp(disp), .addr_mode(addr_mode), .base_pick(base_pick),
    .index_pick(index_pick), .ea(data_ea), .bp_involved(bp_involved)
  );

  seg_select u_sel (
    .access_kind(access_kind), .bp_involved(bp_involved), .ovr_en(ovr_en),
    .ovr_seg(ovr_seg), .seg_id(seg_id), .is_data(is_data)
  );

  always_comb begin
    if (access_kind == KIND_CODE)       eff_addr = reg_ip;
    else if (access_kind == KIND_STACK) eff_addr = reg_sp;
    else                                eff_addr = data_ea;
  end

  seg_relocate u_rel (
    .seg_file(seg_file), .seg_id(seg_id), .offset(eff_addr),
    .seg_value(seg_value), .phys(phys)
  );

  assign seg_sel   = seg_id;
  assign phys_addr = phys;

  always_comb begin
    p_phys_nibble_r1: assert (phys_addr[3:0] == eff_addr[3:0])
      else $error("low nibble not carried through");
    p_phys_upper_r10: assert (phys_addr[19:4] == 16'(seg_value + {4'b0, eff_addr[15:4]}))
      else $error("upper relocation sum wrong");
    if (access_kind == KIND_CODE)
      p_code_cs_r2: assert (seg_sel == 2'd1 && eff_addr == reg_ip)
        else $error("code fetch not CS:IP");
    if (access_kind == KIND_STACK)
      p_stack_ss_r3: assert (seg_sel == 2'd2 && eff_addr == reg_sp)
        else $error("stack access not SS:SP");
    if (is_data && ovr_en)
      p_override_r9: assert (seg_sel == ovr_seg)
        else $error("override not honoured");
    if (is_data && !ovr_en && bp_involved)
      p_bp_stack_r6: assert (seg_sel == 2'd2)
        else $error("BP access not on stack segment");
  end
endmodule

// File: tb/seg_addr_unit_bench.sv
module seg_addr_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
  logic [15:0] reg_bx, reg_bp, reg_si, reg_di, reg_ip, reg_sp, disp;
  logic [2:0]  addr_mode;
  logic [1:0]  access_kind, ovr_seg;
  logic        base_pick, index_pick, ovr_en;
  logic [15:0] eff_addr;
  logic [1:0]  seg_sel;
  logic [19:0] phys_addr;

  seg_addr_unit u_seg_addr_unit (
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .reg_ip(reg_ip), .reg_sp(reg_sp), .disp(disp), .addr_mode(addr_mode),
    .access_kind(access_kind), .base_pick(base_pick), .index_pick(index_pick),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .eff_addr(eff_addr), .seg_sel(seg_sel), .phys_addr(phys_addr)
  );

  typedef struct {
    int    ea;
    int    seg;
    int    phys;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cycles   = 0;
  bit   done     = 0;

  // Independent reference model written from the requirements.
  function automatic exp_t model(string req);
    exp_t e;
    int base, idx, off, seg, segv;
    bit bpuse;
    base  = base_pick ? int'(reg_bp) : int'(reg_bx);
    idx   = index_pick ? int'(reg_di) : int'(reg_si);
    bpuse = 0;
    if (access_kind == 2'd0) begin
      seg = 1; off = int'(reg_ip);
    end else if (access_kind == 2'd2) begin
      seg = 2; off = int'(reg_sp);
    end else begin
      case (addr_mode)
        3'd1: begin off = base; bpuse = base_pick; end
        3'd2: off = idx;
        3'd3: begin off = base + int'(disp); bpuse = base_pick; end
        3'd4: off = idx + int'(disp);
        3'd5: begin off = base + idx + int'(disp); bpuse = base_pick; end
        default: off = int'(disp);
      endcase
      off = off % 65536;
      if (ovr_en) seg = int'(ovr_seg);
      else        seg = bpuse ? 2 : 3;
    end
    case (seg)
      0: segv = int'(seg_es);
      1: segv = int'(seg_cs);
      2: segv = int'(seg_ss);
      default: segv = int'(seg_ds);
    endcase
    e.ea   = off;
    e.seg  = seg;
    e.phys = (segv * 16 + off) % 1048576;
    e.req  = req;
    return e;
  endfunction

  task automatic push(string req);
    q.push_back(model(req));
    @(posedge clk);
  endtask

  task automatic set_data(input logic [2:0] m, input logic bp, input logic ip_,
                          input logic [15:0] d);
    access_kind = 2'd1; addr_mode = m; base_pick = bp; index_pick = ip_;
    disp = d; ovr_en = 1'b0;
  endtask

  // Monitor: compare at the falling edge, half a cycle after inputs settle.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (int'(eff_addr) != e.ea || int'(seg_sel) != e.seg || int'(phys_addr) != e.phys) begin
        n_fail++;
        $display("FAIL %s: ea=%h seg=%0d phys=%h expected ea=%h seg=%0d phys=%h",
                 e.req, eff_addr, seg_sel, phys_addr, e.ea[15:0], e.seg, e.phys[19:0]);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected <5000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    seg_es = '0; seg_cs = '0; seg_ss = '0; seg_ds = '0;
    reg_bx = '0; reg_bp = '0; reg_si = '0; reg_di = '0; reg_ip = '0; reg_sp = '0;
    disp = '0; addr_mode = '0; access_kind = '0; base_pick = 0; index_pick = 0;
    ovr_en = 0; ovr_seg = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    push("R2 reset state");

    // R1 example
    #1; seg_ds = 16'h0100; set_data(3'd0, 0, 0, 16'h0123); push("R1");
    // R2 code fetch, override and mode ignored
    #1; seg_cs = 16'h0100; reg_ip = 16'h4321; access_kind = 2'd0; push("R2");
    #1; ovr_en = 1; ovr_seg = 2'd0; addr_mode = 3'd5; push("R2 override ignored");
    // Distinct register values
    #1; seg_es = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h4000;
    reg_bx = 16'h1111; reg_bp = 16'h2222; reg_si = 16'h0333; reg_di = 16'h0444;
    reg_sp = 16'hFFFE;
    access_kind = 2'd2; ovr_en = 0; push("R3");
    #1; ovr_en = 1; ovr_seg = 2'd3; push("R3 override ignored");
    #1; set_data(3'd0, 1, 1, 16'h5678); push("R4");
    #1; set_data(3'd1, 0, 0, 16'h0099); push("R5 BX");
    #1; set_data(3'd1, 1, 0, 16'h0099); push("R5 BP");
    #1; set_data(3'd2, 1, 0, 16'h0099); push("R5 SI");
    #1; set_data(3'd2, 1, 1, 16'h0099); push("R5 DI");
    #1; set_data(3'd3, 0, 1, 16'h0010); push("R6 BX");
    #1; set_data(3'd3, 1, 1, 16'h0010); push("R6 BP");
    #1; set_data(3'd3, 1, 0, 16'hF000); reg_bp = 16'h2222; push("R6 wrap");
    #1; set_data(3'd4, 1, 0, 16'h0020); push("R7 SI");
    #1; set_data(3'd4, 0, 1, 16'hFFF0); push("R7 DI wrap");
    #1; set_data(3'd5, 0, 1, 16'h0008); push("R8 BX+DI+8");
    #1; set_data(3'd5, 1, 0, 16'hEEEE); push("R8 BP+SI wrap");
    // R9 overrides
    #1; set_data(3'd5, 1, 0, 16'd24); ovr_en = 1; ovr_seg = 2'd0; push("R9 ES:BP+SI+24");
    #1; set_data(3'd0, 0, 0, 16'h0122); ovr_en = 1; ovr_seg = 2'd1; push("R9 CS data");
    #1; set_data(3'd3, 0, 0, 16'h0004); ovr_en = 1; ovr_seg = 2'd2; push("R9 SS over BX");
    // R10 wrap
    #1; seg_ds = 16'hFF20; set_data(3'd0, 0, 0, 16'h0DFF); push("R10 top");
    #1; set_data(3'd0, 0, 0, 16'h0E00); push("R10 wrap zero");
    #1; set_data(3'd0, 0, 0, 16'hFFFF); push("R10 wrap end");
    // R11 reserved codes
    #1; seg_ds = 16'h4000; set_data(3'd6, 1, 1, 16'h0ABC); push("R11 mode6");
    #1; set_data(3'd7, 1, 0, 16'h0DEF); push("R11 mode7");
    #1; set_data(3'd5, 0, 0, 16'h0001); access_kind = 2'd3; push("R11 kind3");
    #1; ovr_en = 1; ovr_seg = 2'd0; push("R11 kind3 override");

    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule